// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Error-Injecting Loopback

This block is a full-duplex asynchronous serial port with no FIFO. The transmit side has one holding register in front of a shift register. The receive side delivers each finished character into a single data register that software reads. The frame format is set by a few static configuration inputs: 7 or 8 data bits, an optional even or odd parity bit, and 1 or 2 stop bits. Data goes out least significant bit first.

The bit timing comes from an 8-bit divider that runs on its own baud clock, separate from the bus clock. It produces a tick at 16 times the bit rate, and the tick is carried into the bus clock domain. A halt input freezes this divider, and every frame in progress stops with it.

For self-test, a loopback mode sends the transmitter's output straight into the receiver. Loopback can also corrupt traffic on purpose: it can flip the parity bit, send a low stop bit, or raise the overrun flag. Software can then exercise its error handling without an external partner.

Top module: `uart_lbk`

## Requirements
- R1: After reset, `txd` is 1, `txReady` is 1, `rxValid` is 0, and `parErr`, `frmErr` and `ovrErr` are all 0.
- R2: Each frame carries 8 data bits when `cfgLen8`=1 and 7 when `cfgLen8`=0, least significant bit first, right after a 0 start bit. A received 7-bit character reads back with `rxData[7]`=0.
- R3: The transmitter sends one stop bit of value 1 when `cfgStop2`=0 and two when `cfgStop2`=1. The receiver examines only the first stop bit.
- R4: When `cfgParEn`=1, a parity bit follows the data bits. It makes the count of ones over data plus parity even when `cfgParOdd`=0 and odd when `cfgParOdd`=1. No parity bit is sent or expected when `cfgParEn`=0.
- R5: `parErr` is loaded with each stored character. It is 1 when parity is enabled and the received parity bit does not match the rule of R4.
- R6: `frmErr` is loaded with each stored character. It is 1 when the first stop bit is sampled as 0.
- R7: If a character completes while `rxValid` is 1 and no read is taking place, `ovrErr` is set and the stored data and flags stay unchanged. A one-cycle `rxRead` pulse clears `rxValid` and `ovrErr`.
- R8: With `loopEn`=1, the transmitted frame drives the receiver internally, `rxd` is ignored, and `txd` stays at 1.
- R9: In loopback, `forceParErr` inverts the transmitted parity bit and `forceFrmErr` sends the first stop bit as 0. `forceOvrErr` sets `ovrErr` when the next character completes; that character is still stored if the register was empty.
- R10: One baud tick occurs every `cfgDiv`+1 cycles of `baudClk`, and every bit of a frame lasts 16 ticks.
- R11: While `halt` is 1, the baud divider stops, so no frame moves forward and no character completes. Frames resume when `halt` returns to 0.
- R12: A start bit is accepted only after a high-to-low transition of the receive line and a 0 seen again at the 8th tick. A shorter low pulse is discarded.
- R13: `txReady` is 1 exactly when the holding register is empty. A `txWrite` while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| baudClk | input | 1 | Independent clock of the baud divider |
| halt | input | 1 | Freezes the baud divider while 1 |
| cfgDiv | input | 8 | Baud divider value; a tick every cfgDiv+1 baudClk cycles |
| cfgLen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgStop2 | input | 1 | 1: two stop bits, 0: one |
| cfgParEn | input | 1 | Parity bit present |
| cfgParOdd | input | 1 | 1: odd parity, 0: even parity |
| loopEn | input | 1 | Internal loopback from transmitter to receiver |
| forceParErr | input | 1 | Loopback only: invert transmitted parity bit |
| forceFrmErr | input | 1 | Loopback only: send first stop bit as 0 |
| forceOvrErr | input | 1 | Loopback only: flag overrun on next character |
| txData | input | 8 | Character to transmit |
| txWrite | input | 1 | Writes txData into the holding register |
| txReady | output | 1 | Holding register is empty |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rxData | output | 8 | Last stored received character |
| rxValid | output | 1 | rxData holds an unread character |
| rxRead | input | 1 | Acknowledges rxData |
| parErr | output | 1 | Parity error of stored character |
| frmErr | output | 1 | Framing error of stored character |
| ovrErr | output | 1 | Overrun since last read |

## Verification
The hardest state to reach is a real frame held partway through by `halt`. The bench lets a loopback frame start, waits about three bit times, raises `halt` for far longer than the rest of the frame would need, and checks that no character appears before release and that the right one appears after it. Back-to-back loopback writes fill the holding register while the shifter is busy, so the test can show that a third write is dropped. Receiving two external frames without a read gives a natural overrun.

// File: rtl/uart_lbk_pkg.sv
package uart_lbk_pkg;
  localparam int OVS    = 16;
  localparam int TICK_W = $clog2(OVS);
  localparam int MID    = OVS / 2 - 1;
  localparam int LAST   = OVS - 1;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } txPhase_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rxPhase_e;

  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    logic     txStopLate;
    txPhase_e txPhase;
    logic     rxClear;
    logic     rxShift;
    logic     rxParTake;
    logic     rxStopTake;
  } strobe_t;
endpackage

// File: rtl/uart_lbk_baud.sv
module uart_lbk_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             baudClk,
  input  logic             rstN,
  input  logic             halt,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic             haltS1, haltS2;
  logic [DIV_W-1:0] cnt;
  logic             tgl;
  logic             t1, t2, t3;

  always_ff @(posedge baudClk or negedge rstN) begin
    if (!rstN) begin
      haltS1 <= 1'b0;
      haltS2 <= 1'b0;
      cnt    <= '0;
      tgl    <= 1'b0;
    end else begin
      haltS1 <= halt;
      haltS2 <= haltS1;
      if (!haltS2) begin
        if (cnt >= div) begin
          cnt <= '0;
          tgl <= ~tgl;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t1 <= 1'b0;
      t2 <= 1'b0;
      t3 <= 1'b0;
    end else begin
      t1 <= tgl;
      t2 <= t1;
      t3 <= t2;
    end
  end

  assign tick = t2 ^ t3;

  // R11
  halt_freeze_chk: assert property (@(posedge baudClk) disable iff (!rstN)
    haltS2 |=> $stable(cnt) && $stable(tgl));

  // R10
  div_wrap_chk: assert property (@(posedge baudClk) disable iff (!rstN)
    (!haltS2 && cnt < div) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/uart_lbk_ctrl.sv
module uart_lbk_ctrl
  import uart_lbk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    holdFull,
  input  logic    rxLine,
  input  logic    cfgLen8,
  input  logic    cfgStop2,
  input  logic    cfgParEn,
  output strobe_t st
);
  txPhase_e          txState;
  logic [TICK_W-1:0] txTicks;
  logic [3:0]        txBits;
  rxPhase_e          rxState;
  logic [TICK_W-1:0] rxTicks;
  logic [3:0]        rxBits;
  logic              armed;
  logic [3:0]        lastData;
  logic              txBitEnd, rxBitEnd, rxMidStart;

  assign lastData   = cfgLen8 ? 4'd7 : 4'd6;
  assign txBitEnd   = tick && (txTicks == TICK_W'(LAST));
  assign rxBitEnd   = tick && (rxTicks == TICK_W'(LAST));
  assign rxMidStart = tick && (rxTicks == TICK_W'(MID));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txTicks <= '0;
      txBits  <= '0;
    end else if (txState == TX_IDLE) begin
      if (holdFull) begin
        txState <= TX_START;
        txTicks <= '0;
        txBits  <= '0;
      end
    end else if (tick) begin
      txTicks <= txTicks + 1'b1;
      if (txBitEnd) begin
        txTicks <= '0;
        case (txState)
          TX_START: txState <= TX_DATA;
          TX_DATA: begin
            if (txBits == lastData) begin
              txBits  <= '0;
              txState <= cfgParEn ? TX_PAR : TX_STOP;
            end else begin
              txBits <= txBits + 1'b1;
            end
          end
          TX_PAR: txState <= TX_STOP;
          default: begin
            if (cfgStop2 && txBits == 4'd0) txBits <= 4'd1;
            else txState <= TX_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTicks <= '0;
      rxBits  <= '0;
      armed   <= 1'b0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (armed && !rxLine) begin
            rxState <= RX_START;
            rxTicks <= '0;
            armed   <= 1'b0;
          end else if (rxLine) begin
            armed <= 1'b1;
          end
        end
        RX_START: begin
          if (tick) begin
            rxTicks <= rxTicks + 1'b1;
            if (rxMidStart) begin
              rxTicks <= '0;
              rxBits  <= '0;
              rxState <= rxLine ? RX_IDLE : RX_DATA;
            end
          end
        end
        default: begin
          if (tick) begin
            rxTicks <= rxTicks + 1'b1;
            if (rxBitEnd) begin
              rxTicks <= '0;
              case (rxState)
                RX_DATA: begin
                  if (rxBits == lastData) rxState <= cfgParEn ? RX_PAR : RX_STOP;
                  else rxBits <= rxBits + 1'b1;
                end
                RX_PAR:  rxState <= RX_STOP;
                default: begin
                  rxState <= RX_IDLE;
                  armed   <= 1'b0;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    st            = '0;
    st.txLoad     = (txState == TX_IDLE) && holdFull;
    st.txShift    = (txState == TX_DATA) && txBitEnd;
    st.txStopLate = (txState == TX_STOP) && (txBits != 4'd0);
    st.txPhase    = txState;
    st.rxClear    = (rxState == RX_START) && rxMidStart && !rxLine;
    st.rxShift    = (rxState == RX_DATA) && rxBitEnd;
    st.rxParTake  = (rxState == RX_PAR) && rxBitEnd;
    st.rxStopTake = (rxState == RX_STOP) && rxBitEnd;
  end

  // R12
  false_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && rxMidStart && rxLine) |=> rxState == RX_IDLE);

  // R13
  tx_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE && holdFull) |=> txState == TX_START);
endmodule

// File: rtl/uart_lbk_dp.sv
module uart_lbk_dp
  import uart_lbk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic       rxdPin,
  input  logic       loopEn,
  input  logic       forcePar,
  input  logic       forceFrm,
  input  logic       forceOvr,
  input  logic       cfgLen8,
  input  logic       cfgParEn,
  input  logic       cfgParOdd,
  input  logic [7:0] txData,
  input  logic       txWrite,
  input  logic       rxRead,
  output logic       holdFull,
  output logic       txLine,
  output logic       rxLine,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       parErr,
  output logic       frmErr,
  output logic       ovrErr
);
  logic [7:0] holdReg, txShreg, rxShreg, rxWord;
  logic       txParBit, txBitNext;
  logic       rxS1, rxS2, rxRaw;
  logic       parAcc, rxParSeen, validEff, pErrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (st.txLoad) begin
      holdFull <= 1'b0;
    end else if (txWrite && !holdFull) begin
      holdReg  <= txData;
      holdFull <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShreg  <= '0;
      txParBit <= 1'b0;
    end else if (st.txLoad) begin
      txShreg  <= holdReg;
      txParBit <= (cfgLen8 ? ^holdReg : ^holdReg[6:0]) ^ cfgParOdd ^ (loopEn & forcePar);
    end else if (st.txShift) begin
      txShreg <= {1'b0, txShreg[7:1]};
    end
  end

  always_comb begin
    case (st.txPhase)
      TX_START: txBitNext = 1'b0;
      TX_DATA:  txBitNext = txShreg[0];
      TX_PAR:   txBitNext = txParBit;
      TX_STOP:  txBitNext = st.txStopLate | ~(loopEn & forceFrm);
      default:  txBitNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txLine <= 1'b1;
    else       txLine <= txBitNext;
  end

  assign rxRaw = loopEn ? txLine : rxdPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1;
      rxS2 <= 1'b1;
    end else begin
      rxS1 <= rxRaw;
      rxS2 <= rxS1;
    end
  end
  assign rxLine = rxS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShreg   <= '0;
      parAcc    <= 1'b0;
      rxParSeen <= 1'b0;
    end else if (st.rxClear) begin
      rxShreg <= '0;
      parAcc  <= 1'b0;
    end else if (st.rxShift) begin
      rxShreg <= {rxLine, rxShreg[7:1]};
      parAcc  <= parAcc ^ rxLine;
    end else if (st.rxParTake) begin
      rxParSeen <= rxLine;
    end
  end

  assign rxWord   = cfgLen8 ? rxShreg : {1'b0, rxShreg[7:1]};
  assign validEff = rxValid && !rxRead;
  assign pErrNow  = cfgParEn && (parAcc ^ rxParSeen ^ cfgParOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      parErr  <= 1'b0;
      frmErr  <= 1'b0;
      ovrErr  <= 1'b0;
    end else begin
      if (rxRead) begin
        rxValid <= 1'b0;
        ovrErr  <= 1'b0;
      end
      if (st.rxStopTake) begin
        if (!validEff) begin
          rxData  <= rxWord;
          parErr  <= pErrNow;
          frmErr  <= !rxLine;
          rxValid <= 1'b1;
        end
        if (validEff || (loopEn && forceOvr)) ovrErr <= 1'b1;
      end
    end
  end

  // R7
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxRead) |=> rxValid && $stable(rxData));

  // R7
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrErr) |-> $past(st.rxStopTake));

  // R13
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !st.txLoad) |=> holdFull && $stable(holdReg));
endmodule

// File: rtl/uart_lbk.sv
module uart_lbk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudClk,
  input  logic             halt,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgLen8,
  input  logic             cfgStop2,
  input  logic             cfgParEn,
  input  logic             cfgParOdd,
  input  logic             loopEn,
  input  logic             forceParErr,
  input  logic             forceFrmErr,
  input  logic             forceOvrErr,
  input  logic [7:0]       txData,
  input  logic             txWrite,
  output logic             txReady,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxRead,
  output logic             parErr,
  output logic             frmErr,
  output logic             ovrErr
);
  import uart_lbk_pkg::*;

  logic    tick, holdFull, txLine, rxLine;
  strobe_t st;

  uart_lbk_baud #(.DIV_W(DIV_W)) uBaud (
    .clk(clk), .baudClk(baudClk), .rstN(rstN), .halt(halt),
    .div(cfgDiv), .tick(tick)
  );

  uart_lbk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .holdFull(holdFull),
    .rxLine(rxLine), .cfgLen8(cfgLen8), .cfgStop2(cfgStop2),
    .cfgParEn(cfgParEn), .st(st)
  );

  uart_lbk_dp uDp (
    .clk(clk), .rstN(rstN), .st(st), .rxdPin(rxd), .loopEn(loopEn),
    .forcePar(forceParErr), .forceFrm(forceFrmErr), .forceOvr(forceOvrErr),
    .cfgLen8(cfgLen8), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .txData(txData), .txWrite(txWrite), .rxRead(rxRead),
    .holdFull(holdFull), .txLine(txLine), .rxLine(rxLine),
    .rxData(rxData), .rxValid(rxValid), .parErr(parErr),
    .frmErr(frmErr), .ovrErr(ovrErr)
  );

  assign txReady = !holdFull;
  assign txd     = loopEn ? 1'b1 : txLine;
endmodule

// File: tb/sim_uart_lbk.sv
`timescale 1ns/1ps
module sim_uart_lbk;
  logic       clk = 1'b0, baudClk = 1'b0, rstN = 1'b0, halt = 1'b0;
  logic [7:0] cfgDiv = 8'd2;
  logic       cfgLen8 = 1'b1, cfgStop2 = 1'b0, cfgParEn = 1'b0, cfgParOdd = 1'b0;
  logic       loopEn = 1'b0, forceParErr = 1'b0, forceFrmErr = 1'b0, forceOvrErr = 1'b0;
  logic [7:0] txData = '0;
  logic       txWrite = 1'b0, rxd = 1'b1, rxRead = 1'b0;
  logic       txReady, txd, rxValid, parErr, frmErr, ovrErr;
  logic [7:0] rxData;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  always #7 baudClk = ~baudClk;

  uart_lbk u0 (
    .clk(clk), .rstN(rstN), .baudClk(baudClk), .halt(halt), .cfgDiv(cfgDiv),
    .cfgLen8(cfgLen8), .cfgStop2(cfgStop2), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .loopEn(loopEn), .forceParErr(forceParErr), .forceFrmErr(forceFrmErr),
    .forceOvrErr(forceOvrErr), .txData(txData), .txWrite(txWrite), .txReady(txReady),
    .txd(txd), .rxd(rxd), .rxData(rxData), .rxValid(rxValid), .rxRead(rxRead),
    .parErr(parErr), .frmErr(frmErr), .ovrErr(ovrErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitLen();
    return 16 * (int'(cfgDiv) + 1);
  endfunction

  function automatic void buildFrame(input logic [7:0] d, input bit l8, input bit pe,
      input bit od, input bit s2, input bit flipP, input bit zeroS,
      output logic [15:0] fr, output int n);
    logic p;
    fr = '0;
    fr[0] = 1'b0;
    n = 1;
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin
      fr[n] = d[i];
      n++;
    end
    p = (l8 ? ^d : ^d[6:0]) ^ od ^ flipP;
    if (pe) begin
      fr[n] = p;
      n++;
    end
    fr[n] = !zeroS;
    n++;
    if (s2) begin
      fr[n] = 1'b1;
      n++;
    end
  endfunction

  task automatic waitBaud(input int n);
    repeat (n) @(posedge baudClk);
  endtask

  task automatic sendChar(input logic [7:0] d);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData  = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic waitRx(output bit got);
    got = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (rxValid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic readRx(output logic [7:0] d, output logic [2:0] fl);
    @(negedge clk);
    d  = rxData;
    fl = {parErr, frmErr, ovrErr};
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic driveRx(input logic [7:0] d, input bit badPar, input bit badStop);
    logic [15:0] fr;
    int n;
    buildFrame(d, cfgLen8, cfgParEn, cfgParOdd, cfgStop2, badPar, badStop, fr, n);
    for (int i = 0; i < n; i++) begin
      @(posedge baudClk);
      rxd <= fr[i];
      waitBaud(bitLen() - 1);
    end
    @(posedge baudClk);
    rxd <= 1'b1;
    waitBaud(bitLen());
  endtask

  task automatic captureTx(output logic [15:0] got, input int n);
    int guard = 0;
    got = '0;
    @(negedge clk);
    while (txd && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    waitBaud(bitLen() / 2);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      waitBaud(bitLen());
      got[i] = txd;
    end
  endtask

  task automatic loopOne(input logic [7:0] d, input string tag,
      input logic [7:0] expD, input logic [2:0] expF);
    bit got;
    logic [7:0] rd;
    logic [2:0] fl;
    sendChar(d);
    waitRx(got);
    chk(got, {tag, " rx arrival"}, int'(got), 1);
    chk(txd == 1'b1, "R8 txd idle in loopback", int'(txd), 1);
    readRx(rd, fl);
    chk(rd == expD, {tag, " data"}, int'(rd), int'(expD));
    chk(fl == expF, {tag, " flags"}, int'(fl), int'(expF));
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : mainSeq
    logic [15:0] fr, cap;
    int n, bad;
    bit got;
    logic [7:0] rd, d;
    logic [2:0] fl;
    void'($urandom(32'd2024));

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(txReady == 1'b1, "R1 txReady", int'(txReady), 1);
    chk(rxValid == 1'b0, "R1 rxValid", int'(rxValid), 0);
    chk({parErr, frmErr, ovrErr} == 3'b0, "R1 flags", int'({parErr, frmErr, ovrErr}), 0);

    // R2 R3 R4 R8 random loopback traffic, rxd held low and ignored
    loopEn = 1'b1;
    rxd    = 1'b0;
    for (int k = 0; k < 8; k++) begin
      cfgLen8   = 1'($urandom);
      cfgStop2  = 1'($urandom);
      cfgParEn  = 1'($urandom);
      cfgParOdd = 1'($urandom);
      cfgDiv    = 8'(1 + ($urandom % 2));
      d = 8'($urandom);
      loopOne(d, "R2 R4 loopback random", cfgLen8 ? d : {1'b0, d[6:0]}, 3'b000);
    end
    rxd = 1'b1;
    repeat (100) @(negedge clk);

    // R2 R3 R4 R10 transmitted waveform at the txd pin
    loopEn = 1'b0;
    cfgDiv = 8'd1; cfgLen8 = 1'b1; cfgStop2 = 1'b0; cfgParEn = 1'b0;
    buildFrame(8'hA5, 1, 0, 0, 0, 0, 0, fr, n);
    sendChar(8'hA5);
    captureTx(cap, n);
    chk(cap == fr, "R10 R2 frame 8N1", int'(cap), int'(fr));
    waitBaud(2 * bitLen());
    cfgDiv = 8'd3; cfgLen8 = 1'b0; cfgStop2 = 1'b1; cfgParEn = 1'b1; cfgParOdd = 1'b0;
    buildFrame(8'h3C, 0, 1, 0, 1, 0, 0, fr, n);
    sendChar(8'h3C);
    captureTx(cap, n);
    chk(cap == fr, "R3 R4 frame 7E2", int'(cap), int'(fr));
    waitBaud(2 * bitLen());
    cfgDiv = 8'd2; cfgLen8 = 1'b1; cfgStop2 = 1'b0; cfgParOdd = 1'b1;
    buildFrame(8'h81, 1, 1, 1, 0, 0, 0, fr, n);
    sendChar(8'h81);
    captureTx(cap, n);
    chk(cap == fr, "R4 frame 8O1", int'(cap), int'(fr));
    waitBaud(2 * bitLen());
    chk(rxValid == 1'b0, "R8 no rx from own tx outside loopback", int'(rxValid), 0);

    // R5 R6 external receive, 8 bits even parity
    cfgParOdd = 1'b0;
    driveRx(8'h5A, 0, 0);
    waitRx(got);
    readRx(rd, fl);
    chk(rd == 8'h5A && fl == 3'b000, "R5 clean receive", int'({fl, rd}), 16'h05A);
    driveRx(8'h5B, 1, 0);
    waitRx(got);
    readRx(rd, fl);
    chk(rd == 8'h5B && fl == 3'b100, "R5 parity error", int'({fl, rd}), 16'h45B);
    driveRx(8'h6C, 0, 1);
    waitRx(got);
    readRx(rd, fl);
    chk(rd == 8'h6C && fl == 3'b010, "R6 framing error", int'({fl, rd}), 16'h26C);

    // R2 seven-bit receive clears bit 7
    cfgLen8 = 1'b0; cfgParEn = 1'b0;
    driveRx(8'hD5, 0, 0);
    waitRx(got);
    readRx(rd, fl);
    chk(rd == 8'h55, "R2 seven-bit receive", int'(rd), 8'h55);
    cfgLen8 = 1'b1;

    // R12 short low pulse rejected
    @(posedge baudClk);
    rxd <= 1'b0;
    waitBaud(bitLen() / 4);
    rxd <= 1'b1;
    waitBaud(3 * bitLen());
    chk(rxValid == 1'b0, "R12 glitch ignored", int'(rxValid), 0);

    // R7 natural overrun
    driveRx(8'h11, 0, 0);
    driveRx(8'h22, 0, 0);
    @(negedge clk);
    chk(rxValid && ovrErr && rxData == 8'h11, "R7 overrun keeps first",
        int'({ovrErr, rxData}), 16'h111);
    readRx(rd, fl);
    @(negedge clk);
    chk(!rxValid && !ovrErr, "R7 read clears", int'({rxValid, ovrErr}), 0);

    // R9 forced errors in loopback
    loopEn = 1'b1; cfgParEn = 1'b1; cfgParOdd = 1'b0; cfgStop2 = 1'b0;
    forceParErr = 1'b1;
    loopOne(8'h33, "R9 forced parity", 8'h33, 3'b100);
    forceParErr = 1'b0;
    forceFrmErr = 1'b1;
    loopOne(8'h44, "R9 forced framing", 8'h44, 3'b010);
    forceFrmErr = 1'b0;
    repeat (50) @(negedge clk);
    forceOvrErr = 1'b1;
    loopOne(8'h55, "R9 forced overrun", 8'h55, 3'b001);
    forceOvrErr = 1'b0;

    // R13 write while holding register full is dropped
    cfgParEn = 1'b0;
    sendChar(8'h61);
    sendChar(8'h62);
    chk(txReady == 1'b0, "R13 holding full", int'(txReady), 0);
    txData = 8'h63; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    waitRx(got);
    readRx(rd, fl);
    chk(rd == 8'h61, "R13 first char", int'(rd), 8'h61);
    waitRx(got);
    readRx(rd, fl);
    chk(rd == 8'h62, "R13 second char", int'(rd), 8'h62);
    waitBaud(25 * bitLen());
    chk(rxValid == 1'b0, "R13 dropped write not sent", int'(rxValid), 0);

    // R11 halt freezes an active frame
    sendChar(8'h9C);
    waitBaud(3 * bitLen());
    halt = 1'b1;
    bad = 0;
    repeat (3000) begin
      @(negedge clk);
      if (rxValid) bad++;
    end
    chk(bad == 0, "R11 no progress in halt", bad, 0);
    halt = 1'b0;
    waitRx(got);
    readRx(rd, fl);
    chk(got && rd == 8'h9C, "R11 resumes after halt", int'(rd), 8'h9C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule